// File: doc/BRIEF.md
# Keypad Sequence Lock

This block is the control core of an electronic door lock. A keypad front end, which this block does not include, delivers one decoded key per press. It presents a 4-bit key code together with a strobe that is high for a single clock cycle. The lock compares each strobed key with the next symbol of a fixed three-key unlock code. It moves forward one step for each correct key and falls back when a key is wrong.

When the last symbol of the code is accepted, the lock enters an open period. During that period it drives a relay output high for a fixed time, and an indicator output blinks at a fixed rate. Keys pressed during the open period are not acted on. When the open time ends, the lock returns to its idle state.

An optional entry timeout sends a partly entered code back to idle if the code is not finished in time. The lock runs from a slow system clock. All durations are counted in cycles of that clock.

Top module: `keypad_seq_lock`

## Requirements
- R1: While reset is asserted, and on the first sample after reset is released, `relay_on` and `led_blink` are low and the lock is idle.
- R2: The unlock code is the key codes 3, 9 and 0xF (the hash key), each accepted on a strobe. Strobes need not be consecutive. `relay_on` goes high in the cycle after the clock edge that accepts 0xF as the third symbol.
- R3: `relay_on` stays high for exactly CLK_HZ*OPEN_SEC cycles, which is 2000 with the defaults. It then goes low and the lock is idle again.
- R4: During the open period, `led_blink` is high for the first CLK_HZ/(2*BLINK_HZ) cycles, which is 50 with the defaults. It then alternates level every 50 cycles. Whenever `relay_on` is low, `led_blink` is low.
- R5: A strobed key that does not match the next expected symbol sends the lock back to idle. The exception is a strobed 3 outside the open period: it always leaves the lock with the first symbol matched.
- R6: Strobed keys during the open period have no effect: they neither shorten nor restart the relay time or the blink pattern.
- R7: `key_code` is ignored while `key_vld` is low. Each cycle with `key_vld` high counts as one separate press, so a strobe held for two cycles counts as two presses.
- R8: With TIMEOUT_EN set, the entry timer starts at the edge that accepts the first 3 taken in idle. If 0xF has not been accepted within CLK_HZ*TIMEOUT_SEC cycles (6000 with the defaults), the lock returns to idle. The timer is not restarted by a repeated 3. It is cleared only when the lock is idle.
- R9: When a strobe arrives in the last cycle of the entry window, the timeout takes precedence and the key is dropped. A 0xF one cycle earlier still opens the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (slow, CLK_HZ) |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_vld | input | 1 | One-cycle strobe marking a new key press |
| key_code | input | 4 | Key code: 0-9 digits, 0xE star, 0xF hash |
| relay_on | output | 1 | Relay drive, high during the open period |
| led_blink | output | 1 | Blinking indicator during the open period |

## Verification
A lock stuck in an intermediate match state can be seen at the ports by the next strobe. A correct 0xF then fails to raise `relay_on` one cycle later, or a wrong key opens the door. A miscounted open or blink timer shows up as a relay edge or an indicator edge that lands on the wrong cycle, up to 2000 cycles after entry. A wrong entry timer shows up only at the window boundary, 6000 cycles after the first 3. The bench therefore compares both outputs on every cycle against an independent cycle model, and it places keys on both sides of that boundary.

// File: rtl/lock_pkg.sv
package lock_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GOT1 = 2'd1,
    ST_GOT2 = 2'd2,
    ST_OPEN = 2'd3
  } lock_st_e;

  localparam logic [3:0] KEY_HASH  = 4'hF;
  localparam logic [3:0] CODE_SYM0 = 4'd3;
  localparam logic [3:0] CODE_SYM1 = 4'd9;
  localparam logic [3:0] CODE_SYM2 = KEY_HASH;

  function automatic int unsigned secs_to_cycles(int unsigned hz, int unsigned sec);
    return hz * sec;
  endfunction

  function automatic int unsigned half_period_cycles(int unsigned hz, int unsigned blink_hz);
    return hz / (2 * blink_hz);
  endfunction

  // One matching step for a strobed key outside the open period
  function automatic lock_st_e match_step(lock_st_e st, logic [3:0] key);
    lock_st_e nx;
    nx = ST_IDLE;
    if (st == ST_GOT1 && key == CODE_SYM1)      nx = ST_GOT2;
    else if (st == ST_GOT2 && key == CODE_SYM2) nx = ST_OPEN;
    else if (key == CODE_SYM0)                  nx = ST_GOT1;
    return nx;
  endfunction

endpackage

// File: rtl/lock_tick_cnt.sv
module lock_tick_cnt #(
  parameter int unsigned LIMIT = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  localparam int unsigned W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt;

  assign last = run && (cnt == W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else if (last) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/lock_blink.sv
module lock_blink #(
  parameter int unsigned HALF = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic led
);
  logic flip;
  logic phase;

  lock_tick_cnt #(.LIMIT(HALF)) u_half (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (en),
    .last (flip)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase <= 1'b1;
    else if (!en)  phase <= 1'b1;
    else if (flip) phase <= ~phase;
  end

  assign led = en & phase;
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import lock_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      key_vld,
  input  logic [3:0] key_code,
  input  logic      open_last,
  input  logic      tout_last,
  output lock_st_e  state,
  output logic      seq_done
);
  lock_st_e nxt;

  always_comb begin
    nxt = state;
    if (state == ST_OPEN) begin
      if (open_last) nxt = ST_IDLE;
    end else if (tout_last) begin
      nxt = ST_IDLE;
    end else if (key_vld) begin
      nxt = match_step(state, key_code);
    end
  end

  assign seq_done = (state != ST_OPEN) && (nxt == ST_OPEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/keypad_seq_lock.sv
module keypad_seq_lock
  import lock_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 200,
  parameter int unsigned OPEN_SEC    = 10,
  parameter int unsigned BLINK_HZ    = 2,
  parameter int unsigned TIMEOUT_SEC = 30,
  parameter bit          TIMEOUT_EN  = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_vld,
  input  logic [3:0] key_code,
  output logic       relay_on,
  output logic       led_blink
);
  localparam int unsigned OPEN_CYC = secs_to_cycles(CLK_HZ, OPEN_SEC);
  localparam int unsigned HALF_CYC = half_period_cycles(CLK_HZ, BLINK_HZ);
  localparam int unsigned TOUT_CYC = secs_to_cycles(CLK_HZ, TIMEOUT_SEC);

  lock_st_e state;
  logic     open_last;
  logic     tout_last;
  logic     seq_done;

  lock_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_vld  (key_vld),
    .key_code (key_code),
    .open_last(open_last),
    .tout_last(tout_last),
    .state    (state),
    .seq_done (seq_done)
  );

  assign relay_on = (state == ST_OPEN);

  lock_tick_cnt #(.LIMIT(OPEN_CYC)) u_open (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (relay_on),
    .last (open_last)
  );

  generate
    if (TIMEOUT_EN) begin : g_tout
      logic armed;
      assign armed = (state == ST_GOT1) || (state == ST_GOT2);
      lock_tick_cnt #(.LIMIT(TOUT_CYC)) u_tout (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (armed),
        .last (tout_last)
      );
    end else begin : g_no_tout
      assign tout_last = 1'b0;
    end
  endgenerate

  lock_blink #(.HALF(HALF_CYC)) u_blink (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (relay_on),
    .led  (led_blink)
  );
endmodule

// File: rtl/lock_chk.sv
module lock_chk
  import lock_pkg::*;
#(
  parameter int unsigned OPEN_CYC = 2000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       key_vld,
  input logic [3:0] key_code,
  input logic       relay_on,
  input logic       led_blink,
  input lock_st_e   state,
  input logic       open_last,
  input logic       tout_last,
  input logic       seq_done
);
  logic [31:0] z_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        z_run <= '0;
    else if (relay_on) z_run <= z_run + 1'b1;
    else               z_run <= '0;
  end

  AST_LED_INSIDE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    led_blink |-> relay_on); // R4
  AST_LED_STARTS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(relay_on) |-> led_blink); // R4
  AST_DONE_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> relay_on); // R2
  AST_OPEN_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    relay_on |-> (z_run < 32'(OPEN_CYC))); // R3
  AST_OPEN_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    open_last |=> (state == ST_IDLE && !relay_on)); // R3
  AST_OPEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (relay_on && !open_last) |=> relay_on); // R6
  AST_WRONG_KEY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GOT1 && key_vld && !tout_last && key_code != 4'd9 && key_code != 4'd3)
      |=> state == ST_IDLE); // R5
  AST_THREE_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_OPEN && key_vld && !tout_last && key_code == 4'd3) |=> state == ST_GOT1); // R5
  AST_NO_STROBE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_OPEN && !key_vld && !tout_last) |=> $stable(state)); // R7
  AST_TIMEOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tout_last |=> (state == ST_IDLE && !relay_on)); // R9
  AST_TIMEOUT_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    tout_last |-> (state == ST_GOT1 || state == ST_GOT2)); // R8
endmodule

bind keypad_seq_lock lock_chk #(.OPEN_CYC(CLK_HZ * OPEN_SEC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .key_vld  (key_vld),
  .key_code (key_code),
  .relay_on (relay_on),
  .led_blink(led_blink),
  .state    (state),
  .open_last(open_last),
  .tout_last(tout_last),
  .seq_done (seq_done)
);

// File: tb/sim_keypad_seq_lock.sv
module sim_keypad_seq_lock;
  localparam int HZ     = 200;
  localparam int OPEN_N = HZ * 10;
  localparam int HALF_N = HZ / 4;
  localparam int TOUT_N = HZ * 30;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       key_vld = 1'b0;
  logic [3:0] key_code = 4'd0;
  wire        relay_on;
  wire        led_blink;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model: 0 idle, 1 one matched, 2 two matched, 3 open
  int m_st = 0;
  int m_ocnt = 0;
  int m_tcnt = 0;

  keypad_seq_lock u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_vld  (key_vld),
    .key_code (key_code),
    .relay_on (relay_on),
    .led_blink(led_blink)
  );

  always #10 clk = ~clk;

  function automatic int seq_next(int st, logic [3:0] k);
    if (st == 1 && k == 4'd9) return 2;
    if (st == 2 && k == 4'hF) return 3;
    if (k == 4'd3) return 1;
    return 0;
  endfunction

  function automatic bit exp_led(int k);
    return ((k / HALF_N) % 2) == 0;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge(bit v, logic [3:0] c);
    bit armed;
    int ns;
    armed = (m_st == 1 || m_st == 2);
    if (m_st == 3) begin
      if (m_ocnt == OPEN_N - 1) m_st = 0;
      else m_ocnt++;
    end else if (armed && m_tcnt == TOUT_N - 1) begin
      m_st = 0;
    end else begin
      ns = m_st;
      if (v) ns = seq_next(m_st, c);
      if (ns == 3) m_ocnt = 0;
      if (m_st == 0 && ns == 1) m_tcnt = 0;
      else if (armed) m_tcnt++;
      m_st = ns;
    end
  endtask

  task automatic cyc(bit v, logic [3:0] c, string tag);
    key_vld = v;
    key_code = c;
    @(posedge clk);
    model_edge(v, c);
    @(negedge clk);
    check(tag, relay_on, m_st == 3);
    check("R4", led_blink, (m_st == 3) && exp_led(m_ocnt));
    key_vld = 1'b0;
  endtask

  task automatic press(logic [3:0] c, string tag);
    cyc(1'b1, c, tag);
  endtask

  task automatic wait_n(int n, string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 4'd0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", relay_on, 1'b0);
    check("R1", led_blink, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", relay_on, 1'b0);

    // R2 with gaps between keys, then R3/R4 over the full open period
    press(4'd3, "R2"); wait_n(2, "R2"); press(4'd9, "R2"); wait_n(1, "R2");
    press(4'hF, "R2");
    check("R2", relay_on, 1'b1);
    wait_n(OPEN_N + 5, "R3");
    check("R3", relay_on, 1'b0);

    // R6 keys pressed while open
    press(4'd3, "R6"); press(4'd9, "R6"); press(4'hF, "R6");
    wait_n(100, "R6"); press(4'd3, "R6"); press(4'd9, "R6"); press(4'hF, "R6");
    press(4'hE, "R6");
    wait_n(OPEN_N, "R6");

    // R5 wrong keys and the 3 exception
    press(4'd3, "R5"); press(4'd9, "R5"); press(4'd5, "R5"); press(4'hF, "R5");
    check("R5", relay_on, 1'b0);
    press(4'd3, "R5"); press(4'd9, "R5"); press(4'hE, "R5"); press(4'hF, "R5");
    check("R5", relay_on, 1'b0);
    press(4'd3, "R5"); press(4'd9, "R5"); press(4'd3, "R5"); press(4'd9, "R5");
    press(4'hF, "R5");
    check("R5", relay_on, 1'b1);
    wait_n(OPEN_N, "R5");
    press(4'd3, "R5"); press(4'd3, "R5"); press(4'd9, "R5"); press(4'hF, "R5");
    check("R5", relay_on, 1'b1);
    wait_n(OPEN_N, "R5");

    // R7 code without strobe is ignored; held strobe counts twice
    press(4'd3, "R7"); cyc(1'b0, 4'd9, "R7"); press(4'hF, "R7");
    check("R7", relay_on, 1'b0);
    press(4'd3, "R7"); press(4'd9, "R7"); press(4'd9, "R7"); press(4'hF, "R7");
    check("R7", relay_on, 1'b0);
    press(4'd3, "R7"); cyc(1'b0, 4'd5, "R7"); press(4'd9, "R7"); press(4'hF, "R7");
    check("R7", relay_on, 1'b1);
    wait_n(OPEN_N, "R7");

    // R8 timeout, and a repeated 3 does not restart the window
    press(4'd3, "R8"); wait_n(TOUT_N + 2, "R8");
    press(4'd9, "R8"); press(4'hF, "R8");
    check("R8", relay_on, 1'b0);
    press(4'd3, "R8"); wait_n(3000, "R8"); press(4'd3, "R8");
    wait_n(3100, "R8"); press(4'd9, "R8"); press(4'hF, "R8");
    check("R8", relay_on, 1'b0);

    // R9 boundary: last window cycle loses, one cycle earlier wins
    press(4'd3, "R9"); press(4'd9, "R9"); wait_n(TOUT_N - 2, "R9");
    press(4'hF, "R9");
    check("R9", relay_on, 1'b0);
    press(4'd3, "R9"); press(4'd9, "R9"); wait_n(TOUT_N - 3, "R9");
    press(4'hF, "R9");
    check("R9", relay_on, 1'b1);
    wait_n(OPEN_N, "R9");

    // constrained random presses biased towards the code symbols
    for (int i = 0; i < 20000; i++) begin
      bit v;
      logic [3:0] c;
      int pick;
      v = ($urandom_range(0, 3) == 0);
      pick = $urandom_range(0, 5);
      case (pick)
        0: c = 4'd3;
        1: c = 4'd9;
        2: c = 4'hF;
        default: c = 4'($urandom_range(0, 15));
      endcase
      cyc(v, c, "R2");
    end

    finish_run();
  end
endmodule